// File: doc/BRIEF.md
# Reduced-Generate Sparse Prefix Adder (18-bit)

This block is a purely combinational 18-bit binary adder. Its carry logic avoids the usual generate/propagate prefix terms and uses reduced generates instead. A reduced generate R^p of a span leaves the top p propagate factors out of the ordinary group generate. That makes each prefix node cheaper. A separate network of short carry-survival terms D feeds the sum multiplexers, which put the stripped factors back. The carry-in enters as bit zero of the first operand pair. Only the 18 sum bits leave the block; the final carry-out is dropped.

The front stage reduces each pair of bit positions to one reduced generate, which is the OR of the two bitwise generates. The middle stage combines three pairs into six-bit blocks with a valency-3 recursion. The last stage joins the blocks with a hyperpropagate term, so that every odd prefix boundary gets its own reduced generate. Prefixes exist only at every second column. An even sum bit is picked straight from its prefix through a two-way mux. An odd sum bit adds a one-bit ripple through the generate and propagate of its even neighbour, then uses the same select.

Top module: `jk_adder`

## Requirements
- R1: `sum_o` equals (a_i + b_i + cin_i) modulo 2^18 for every input combination; the carry out of bit 17 is discarded.
- R2: `sum_o[0]` equals `a_i[0] ^ b_i[0] ^ cin_i`.
- R3: With a_i = 2^k - 1, b_i = 0 and cin_i = 1, `sum_o` is 2^k for k from 0 to 17, and zero when a_i is all ones.
- R4: With b_i equal to the bitwise complement of a_i, `sum_o` is all ones when cin_i = 0 and all zeros when cin_i = 1.
- R5: A carry generated at bit k (a_i = 2^18 - 2^k, b_i = 2^k, cin_i = 0) reaches every higher bit, and `sum_o` is zero.
- R6: A position where a_i and b_i are both 0 stops a carry: with a_i all ones except bit k, b_i = 0 and cin_i = 1, `sum_o` is all ones with bits below k cleared.
- R7: The block holds no state. `sum_o` follows a change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 18 | First operand |
| b_i | input | 18 | Second operand |
| cin_i | input | 1 | Carry-in, added at the weight of bit 0 |
| sum_o | output | 18 | Sum bits, carry-out dropped |

## Verification
The operand patterns fall into a few families. Ripple patterns (ones below bit k plus carry-in) drive a carry across each six-bit block edge, so they separate the stage-3 hyperpropagate from the local stage-2 terms. Complementary operands put propagate on every bit with no generate, so only the D selection path can make the sum. Generate-at-k and kill-at-k patterns test the reduced-generate ORs and the stop conditions at every column. Hand-worked table vectors and a few thousand random operand pairs, checked against plain integer addition, cover the mixed cases.

// File: rtl/jk_pkg.sv
package jk_pkg;
  localparam int unsigned PAIRS_PER_BLK = 3;
  localparam int unsigned BITS_PER_BLK  = 2 * PAIRS_PER_BLK;

  // carry survival over three bits, top to bottom, given carry in = 1
  function automatic logic d3(input logic g_hi, input logic p_hi,
                              input logic g_md, input logic p_md, input logic p_lo);
    return g_hi | (p_hi & (g_md | (p_md & p_lo)));
  endfunction
endpackage

// File: rtl/jk_pair_stage.sv
module jk_pair_stage
  import jk_pkg::*;
#(
  parameter int unsigned BLOCKS = 3,
  localparam int unsigned W  = BITS_PER_BLK * BLOCKS,
  localparam int unsigned NP = W / 2
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          cin_i,
  output logic [W:1]    x_o,
  output logic [NP-1:0] gev_o,
  output logic [NP-1:1] pev_o,
  output logic [NP-1:0] pr_o,
  output logic [NP-1:0] dsel_o,
  output logic [BLOCKS-1:0] mid_q_o,
  output logic [BLOCKS-1:0] base_p_o,
  output logic [BLOCKS-1:0] blk_d_o
);
  // internal position k holds operand bit k-1; position 0 is the carry-in
  logic [W-1:0] g;
  logic [W-1:1] p;

  assign g[0] = cin_i;
  assign x_o  = a_i ^ b_i;

  for (genvar k = 1; k < W; k++) begin : g_bit
    assign g[k] = a_i[k-1] & b_i[k-1];
    assign p[k] = a_i[k-1] | b_i[k-1];
  end

  for (genvar m = 0; m < NP; m++) begin : g_pair
    assign pr_o[m]  = g[2*m+1] | g[2*m];
    assign gev_o[m] = g[2*m];
    if (m > 0) begin : g_pev
      assign pev_o[m] = p[2*m];
    end
    if ((m % PAIRS_PER_BLK) == PAIRS_PER_BLK - 1) begin : g_dlong
      assign dsel_o[m] = blk_d_o[m / PAIRS_PER_BLK];
    end else begin : g_dshort
      assign dsel_o[m] = p[2*m+1];
    end
  end

  for (genvar t = 0; t < BLOCKS; t++) begin : g_blk
    localparam int unsigned B0 = BITS_PER_BLK * t;
    assign mid_q_o[t] = p[B0+2] & p[B0+1];
    assign blk_d_o[t] = d3(g[B0+5], p[B0+5], g[B0+4], p[B0+4], p[B0+3]);
    if (t == 0) begin : g_base0
      assign base_p_o[t] = 1'b1;
    end else begin : g_basen
      assign base_p_o[t] = p[B0];
    end
  end
endmodule

// File: rtl/jk_prefix_tree.sv
module jk_prefix_tree
  import jk_pkg::*;
#(
  parameter int unsigned BLOCKS = 3,
  localparam int unsigned NP = PAIRS_PER_BLK * BLOCKS
) (
  input  logic [NP-1:0]     pr_i,
  input  logic [BLOCKS-1:0] mid_q_i,
  input  logic [BLOCKS-1:0] base_p_i,
  input  logic [BLOCKS-1:0] blk_d_i,
  output logic [NP-1:0]     rpre_o
);
  logic [NP-1:0]     loc;    // stage 2: reduced generate inside the block
  logic [NP-1:0]     qx;     // stage 3: hyperpropagate toward the lower prefix
  logic [BLOCKS-1:0] low;    // R^3 prefix ending just below block t
  logic [BLOCKS-1:0] low_d;  // D of the three bits just below block t

  for (genvar t = 0; t < BLOCKS; t++) begin : g_blk
    localparam int unsigned M0 = PAIRS_PER_BLK * t;

    assign loc[M0]   = pr_i[M0];
    assign loc[M0+1] = pr_i[M0+1] | (mid_q_i[t] & pr_i[M0]);
    assign loc[M0+2] = pr_i[M0+2] | pr_i[M0+1] | (mid_q_i[t] & pr_i[M0]);

    if (t == 0) begin : g_first
      assign low[t]   = 1'b0;
      assign low_d[t] = 1'b0;
    end else begin : g_rest
      assign low[t]   = loc[M0-1] | (qx[M0-1] & low[t-1]);
      assign low_d[t] = blk_d_i[t-1];
    end

    assign qx[M0]   = base_p_i[t] & low_d[t];
    assign qx[M0+1] = base_p_i[t] & mid_q_i[t] & low_d[t];
    assign qx[M0+2] = base_p_i[t] & mid_q_i[t] & low_d[t];

    for (genvar u = 0; u < PAIRS_PER_BLK; u++) begin : g_out
      assign rpre_o[M0+u] = loc[M0+u] | (qx[M0+u] & low[t]);
    end
  end
endmodule

// File: rtl/jk_sum_select.sv
module jk_sum_select
  import jk_pkg::*;
#(
  parameter int unsigned BLOCKS = 3,
  localparam int unsigned W  = BITS_PER_BLK * BLOCKS,
  localparam int unsigned NP = W / 2
) (
  input  logic [W:1]    x_i,
  input  logic [NP-1:0] gev_i,
  input  logic [NP-1:1] pev_i,
  input  logic [NP-1:0] dsel_i,
  input  logic [NP-1:0] rpre_i,
  output logic [W-1:0]  sum_o
);
  assign sum_o[0] = x_i[1] ^ gev_i[0];

  for (genvar m = 0; m < NP; m++) begin : g_even
    assign sum_o[2*m+1] = rpre_i[m] ? (x_i[2*m+2] ^ dsel_i[m]) : x_i[2*m+2];
  end

  for (genvar m = 0; m < NP - 1; m++) begin : g_odd
    logic hit, miss;
    assign miss = x_i[2*m+3] ^ gev_i[m+1];
    assign hit  = x_i[2*m+3] ^ (gev_i[m+1] | (pev_i[m+1] & dsel_i[m]));
    assign sum_o[2*m+2] = rpre_i[m] ? hit : miss;
  end
endmodule

// File: rtl/jk_adder.sv
module jk_adder
  import jk_pkg::*;
#(
  parameter int unsigned BLOCKS = 3,
  localparam int unsigned W  = BITS_PER_BLK * BLOCKS,
  localparam int unsigned NP = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W:1]        x;
  logic [NP-1:0]     gev, pr, dsel, rpre;
  logic [NP-1:1]     pev;
  logic [BLOCKS-1:0] mid_q, base_p, blk_d;

  jk_pair_stage #(.BLOCKS(BLOCKS)) u_pair (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .x_o(x), .gev_o(gev), .pev_o(pev), .pr_o(pr), .dsel_o(dsel),
    .mid_q_o(mid_q), .base_p_o(base_p), .blk_d_o(blk_d)
  );

  jk_prefix_tree #(.BLOCKS(BLOCKS)) u_tree (
    .pr_i(pr), .mid_q_i(mid_q), .base_p_i(base_p), .blk_d_i(blk_d),
    .rpre_o(rpre)
  );

  jk_sum_select #(.BLOCKS(BLOCKS)) u_sum (
    .x_i(x), .gev_i(gev), .pev_i(pev), .dsel_i(dsel), .rpre_i(rpre),
    .sum_o(sum_o)
  );
endmodule

// File: rtl/jk_adder_chk.sv
module jk_adder_chk
  import jk_pkg::*;
#(
  parameter int unsigned BLOCKS = 3,
  localparam int unsigned W = BITS_PER_BLK * BLOCKS
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o
);
  logic [W:0] full;
  assign full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    // R1
    sum_mod_chk: assert (sum_o == full[W-1:0]) else $error("sum mismatch");
    // R2
    lsb_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_i)) else $error("lsb mismatch");
    // R3
    wrap_chk: assert (!((&a_i) && (b_i == '0) && cin_i) || (sum_o == '0))
      else $error("wrap mismatch");
    // R4
    comp_chk: assert (!(b_i == ~a_i) || (sum_o == {W{~cin_i}}))
      else $error("complement mismatch");
  end
endmodule

bind jk_adder jk_adder_chk #(.BLOCKS(BLOCKS)) u_chk (.*);

// File: tb/tb_jk_adder.sv
module tb_jk_adder;
  localparam int unsigned W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic         cin;
  int checks = 0;
  int errors = 0;

  jk_adder dut (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum));

  // {a, b, cin, expected sum}
  localparam int unsigned NV = 10;
  localparam logic [3*W:0] VEC [NV] = '{
    {18'h00000, 18'h00000, 1'b0, 18'h00000},
    {18'h3FFFF, 18'h00000, 1'b1, 18'h00000},
    {18'h3FFFF, 18'h3FFFF, 1'b0, 18'h3FFFE},
    {18'h3FFFF, 18'h3FFFF, 1'b1, 18'h3FFFF},
    {18'h2AAAA, 18'h15555, 1'b0, 18'h3FFFF},
    {18'h2AAAA, 18'h15555, 1'b1, 18'h00000},
    {18'h00FFF, 18'h00001, 1'b0, 18'h01000},
    {18'h12345, 18'h0ABCD, 1'b0, 18'h1CF12},
    {18'h00000, 18'h00000, 1'b1, 18'h00001},
    {18'h3F000, 18'h01000, 1'b0, 18'h00000}
  };

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (sum !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b got %h exp %h", req, a, b, cin, sum, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_sum(input logic [W-1:0] va, input logic [W-1:0] vb,
                                           input logic vc);
    logic [W:0] t;
    t = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    return t[W-1:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset state", '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] va, vb, ve;
      logic vc;
      {va, vb, vc, ve} = VEC[i];
      drive(va, vb, vc);
      check("R1 table", ve);
    end

    // R2 low bit for all eight low-bit combinations
    for (int i = 0; i < 8; i++) begin
      drive({17'h15A5A, i[0]}, {17'h0F0F0, i[1]}, i[2]);
      checks++;
      if (sum[0] !== (i[0] ^ i[1] ^ i[2])) begin
        errors++;
        $display("FAIL R2 got %b exp %b", sum[0], i[0] ^ i[1] ^ i[2]);
      end
    end

    // R3 carry-in ripple through k ones
    for (int k = 0; k < W; k++) begin
      drive((ONES >> (W - k)), '0, 1'b1);
      check("R3 ripple", W'(1) << k);
    end
    drive(ONES, '0, 1'b1);
    check("R3 full wrap", '0);

    // R4 complementary operands
    drive(18'h2C3A5, ~18'h2C3A5, 1'b0);
    check("R4 cin0", ONES);
    drive(18'h2C3A5, ~18'h2C3A5, 1'b1);
    check("R4 cin1", '0);

    // R5 generate at k carried to the top
    for (int k = 0; k < W; k++) begin
      drive(ONES << k, W'(1) << k, 1'b0);
      check("R5 generate", '0);
    end

    // R6 kill at k
    for (int k = 0; k < W; k++) begin
      drive(ONES & ~(W'(1) << k), '0, 1'b1);
      check("R6 kill", ONES << k);
    end

    // R7 output follows inputs with no clock edge between
    @(negedge clk);
    a = 18'h00FFF; b = 18'h00001; cin = 1'b0;
    #1;
    check("R7 comb first", 18'h01000);
    a = 18'h3FFFF; b = 18'h00000; cin = 1'b1;
    #1;
    check("R7 comb second", 18'h00000);

    // R1 random operands
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] va, vb;
      logic vc;
      va = W'($urandom);
      vb = W'($urandom);
      vc = 1'($urandom);
      drive(va, vb, vc);
      check("R1 random", ref_sum(va, vb, vc));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule